// File: doc/BRIEF.md
# Byte/word shift-rotate-logic unit

This block is the bit-manipulation execution slice of a 16-bit integer datapath. Each cycle it can accept one operation: a Boolean operation (NOT, AND, OR, XOR, or a flags-only AND test), a shift (left, logical right, arithmetic right), a rotate within the operand, or a rotate through the carry flag. The same datapath serves byte and word operands. The shift amount comes either from an immediate field or from a count register, as chosen by a select input. Only the low five bits of the chosen count take effect.

Operands, opcode, count and the incoming flags are captured on a rising clock edge. The result, a write-enable for the destination and the five updated flags (carry, zero, sign, parity, overflow) appear registered one cycle later with `out_valid`. The surrounding pipeline writes `result` back only when `wr_en` is high. It copies all five flag outputs into its flag register whenever `out_valid` is high, because flags that do not change are passed through from the inputs.

Top module: `bitop_unit`

## Requirements
- R1: An operation presented with `in_valid` high at a rising edge produces `out_valid` high after that edge. A cycle with `in_valid` low produces `out_valid` and `wr_en` low after the next edge.
- R2: TEST (code 4) takes the AND of the operands. It sets zero, sign and parity from that AND, clears carry and overflow, and holds `wr_en` low.
- R3: Code 0 (NOT) gives the inverted operand A with all flags passed through unchanged. Codes 1, 2 and 3 (AND, OR, XOR) give their Boolean result with `wr_en` high. They clear carry and overflow and set zero, sign and parity from the result.
- R4: With `is_word` low, only bits 7:0 of each operand are used and `result[15:8]` is zero. Sign is taken from bit 7, and zero is taken from bits 7:0. In both widths, parity is 1 when bits 7:0 of the result hold an even number of ones.
- R5: `count_sel` high takes the count from `reg_count`, and low takes it from `imm_count`. Only bits 4:0 of the chosen value are used, so 32 and above wrap.
- R6: Code 5 shifts left with zero fill, code 6 shifts right with zero fill, and code 7 shifts right filling with the sign bit (bit 7 for bytes, bit 15 for words). Carry gets the last bit shifted out. Zero, sign and parity come from the result.
- R7: Code 8 rotates left and code 9 rotates right, within the operand width. Carry gets the last bit that wrapped around. Zero, sign and parity are passed through.
- R8: Code 10 rotates left and code 11 rotates right through carry, as one ring of 9 bits (bytes) or 17 bits (words). Carry gets the ring's extra bit. Zero, sign and parity are passed through.
- R9: For codes 5 to 11 with an effective count of zero, `wr_en` is low, all flags equal their inputs, and `result` is operand A at the selected width.
- R10: With an effective count of exactly 1, overflow is set as follows. Codes 5, 8 and 10 give the result MSB XOR the new carry. Code 6 gives the operand MSB. Code 7 gives 0. Codes 9 and 11 give the XOR of the two top result bits. Counts above 1 pass overflow through.
- R11: Codes 12 to 15 hold `wr_en` low, pass all flags through, and return operand A at the selected width.
- R12: While `rst_n` is low, `out_valid`, `wr_en`, `result` and all flag outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code (0 to 11 defined) |
| is_word | input | 1 | 1 = 16-bit operand, 0 = 8-bit operand |
| opnd_a | input | 16 | Destination/source operand |
| opnd_b | input | 16 | Second operand for Boolean operations |
| imm_count | input | 8 | Immediate shift count |
| reg_count | input | 8 | Run-time shift count from the count register |
| count_sel | input | 1 | 1 selects `reg_count`, 0 selects `imm_count` |
| cf_in | input | 1 | Current carry flag |
| zf_in | input | 1 | Current zero flag |
| sf_in | input | 1 | Current sign flag |
| pf_in | input | 1 | Current parity flag |
| of_in | input | 1 | Current overflow flag |
| out_valid | output | 1 | Registered result valid |
| result | output | 16 | Operation result |
| wr_en | output | 1 | Write result back to destination |
| cf_out | output | 1 | Updated carry flag |
| zf_out | output | 1 | Updated zero flag |
| sf_out | output | 1 | Updated sign flag |
| pf_out | output | 1 | Updated parity flag |
| of_out | output | 1 | Updated overflow flag |

## Verification
The bench builds the unit with its defaults: 16-bit data, 8-bit count inputs and a 5-bit effective count. The 32 effective counts go past both the 9-bit and 17-bit carry rings, so full-circle and beyond-circle rotates through carry are reached, as are shifts longer than the operand. The three unused count bits and the four unused opcodes let masking and pass-through be checked against a single-step reference model, for every opcode, both widths and every count.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [3:0] {
    OP_NOT  = 4'd0,
    OP_AND  = 4'd1,
    OP_OR   = 4'd2,
    OP_XOR  = 4'd3,
    OP_TEST = 4'd4,
    OP_SHL  = 4'd5,
    OP_SHR  = 4'd6,
    OP_SAR  = 4'd7,
    OP_ROL  = 4'd8,
    OP_ROR  = 4'd9,
    OP_RCL  = 4'd10,
    OP_RCR  = 4'd11
  } bitop_e;

  typedef struct packed {
    logic cf;
    logic zf;
    logic sf;
    logic pf;
    logic of;
  } flags_t;

  function automatic logic op_is_bool(input logic [3:0] op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_TEST);
  endfunction

  function automatic logic op_is_shift(input logic [3:0] op);
    return (op == OP_SHL) || (op == OP_SHR) || (op == OP_SAR);
  endfunction

  function automatic logic op_is_rot(input logic [3:0] op);
    return (op == OP_ROL) || (op == OP_ROR) || (op == OP_RCL) || (op == OP_RCR);
  endfunction

endpackage

// File: rtl/bitop_count.sv
module bitop_count #(
  parameter int CNT_IN_W = 8,
  parameter int SHAMT_W  = 5
) (
  input  logic [CNT_IN_W-1:0] imm_count,
  input  logic [CNT_IN_W-1:0] reg_count,
  input  logic                count_sel,
  output logic [SHAMT_W-1:0]  shamt,
  output logic                cnt_zero
);
  logic [CNT_IN_W-1:0] raw_count;
  logic                unused_cnt_hi;

  // R5: source select, then keep only the low SHAMT_W bits
  assign raw_count     = count_sel ? reg_count : imm_count;
  assign shamt         = raw_count[SHAMT_W-1:0];
  assign unused_cnt_hi = ^raw_count[CNT_IN_W-1:SHAMT_W];
  assign cnt_zero      = (shamt == '0);
endmodule

// File: rtl/bitop_logic.sv
module bitop_logic
  import bitop_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] width_mask,
  output logic [DATA_W-1:0] bool_res
);
  always_comb begin
    unique case (op)
      OP_NOT:          bool_res = ~a & width_mask;
      OP_AND, OP_TEST: bool_res = a & b;
      OP_OR:           bool_res = a | b;
      OP_XOR:          bool_res = a ^ b;
      default:         bool_res = '0;
    endcase
  end
endmodule

// File: rtl/bitop_zsp.sv
module bitop_zsp #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] value,
  input  logic              is_word,
  output logic              zf,
  output logic              sf,
  output logic              pf
);
  localparam int HALF_W = DATA_W / 2;

  // R4: width-aware zero/sign, parity over the low byte only
  assign zf = is_word ? (value == '0) : (value[HALF_W-1:0] == '0);
  assign sf = is_word ? value[DATA_W-1] : value[HALF_W-1];
  assign pf = ~^value[HALF_W-1:0];
endmodule

// File: rtl/bitop_shift.sv
module bitop_shift
  import bitop_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SHAMT_W = 5
) (
  input  logic [3:0]         op,
  input  logic               is_word,
  input  logic [DATA_W-1:0]  opnd,
  input  logic               cf_in,
  input  logic [SHAMT_W-1:0] shamt,
  output logic [DATA_W-1:0]  sh_res,
  output logic               sh_cf,
  output logic               sh_of1
);
  localparam int HALF_W = DATA_W / 2;
  localparam int RING_W = DATA_W + 1;
  localparam int RING_B = HALF_W + 1;

  // left shifts: one spare bit above the operand catches the carry
  logic [DATA_W:0]   shl_w;
  logic [HALF_W:0]   shl_b;
  // right shifts: fill bit on top, carry catcher below
  logic [DATA_W+1:0] shr_w;
  logic [HALF_W+1:0] shr_b;
  logic              fill_w, fill_b, unused_fill;
  // rotates
  logic [DATA_W-1:0] rot_w;
  logic [HALF_W-1:0] rot_b;
  logic [RING_W-1:0] ring_w, rcr_w;
  logic [RING_B-1:0] ring_b, rcr_b;
  int                amt_w, amt_b, ramt_w, ramt_b;
  logic              left_dir;
  logic              res_msb, res_nxt, opnd_msb;

  function automatic int rot_amount(input int n, input int modulus, input logic left);
    int m;
    m = n % modulus;
    return left ? m : (modulus - m) % modulus;
  endfunction

  assign left_dir = (op == OP_ROL) || (op == OP_RCL);

  always_comb begin
    fill_w = (op == OP_SAR) & opnd[DATA_W-1];
    fill_b = (op == OP_SAR) & opnd[HALF_W-1];
    shl_w  = {1'b0, opnd} << shamt;
    shl_b  = {1'b0, opnd[HALF_W-1:0]} << shamt;
    shr_w  = $signed({fill_w, opnd, 1'b0}) >>> shamt;
    shr_b  = $signed({fill_b, opnd[HALF_W-1:0], 1'b0}) >>> shamt;

    amt_w  = rot_amount(int'(shamt), DATA_W, left_dir);
    amt_b  = rot_amount(int'(shamt), HALF_W, left_dir);
    ramt_w = rot_amount(int'(shamt), RING_W, left_dir);
    ramt_b = rot_amount(int'(shamt), RING_B, left_dir);
    rot_w  = (opnd << amt_w) | (opnd >> (DATA_W - amt_w));
    rot_b  = (opnd[HALF_W-1:0] << amt_b) | (opnd[HALF_W-1:0] >> (HALF_W - amt_b));
    ring_w = {cf_in, opnd};
    ring_b = {cf_in, opnd[HALF_W-1:0]};
    rcr_w  = (ring_w << ramt_w) | (ring_w >> (RING_W - ramt_w));
    rcr_b  = (ring_b << ramt_b) | (ring_b >> (RING_B - ramt_b));
  end

  assign unused_fill = shr_w[DATA_W+1] ^ shr_b[HALF_W+1];

  always_comb begin
    sh_res = opnd;
    sh_cf  = cf_in;
    unique case (op)
      OP_SHL: begin  // R6
        sh_res = is_word ? shl_w[DATA_W-1:0] : {{HALF_W{1'b0}}, shl_b[HALF_W-1:0]};
        sh_cf  = is_word ? shl_w[DATA_W] : shl_b[HALF_W];
      end
      OP_SHR, OP_SAR: begin  // R6
        sh_res = is_word ? shr_w[DATA_W:1] : {{HALF_W{1'b0}}, shr_b[HALF_W:1]};
        sh_cf  = is_word ? shr_w[0] : shr_b[0];
      end
      OP_ROL, OP_ROR: begin  // R7
        sh_res = is_word ? rot_w : {{HALF_W{1'b0}}, rot_b};
        if (op == OP_ROL) sh_cf = is_word ? rot_w[0] : rot_b[0];
        else              sh_cf = is_word ? rot_w[DATA_W-1] : rot_b[HALF_W-1];
      end
      OP_RCL, OP_RCR: begin  // R8
        sh_res = is_word ? rcr_w[DATA_W-1:0] : {{HALF_W{1'b0}}, rcr_b[HALF_W-1:0]};
        sh_cf  = is_word ? rcr_w[DATA_W] : rcr_b[HALF_W];
      end
      default: begin
        sh_res = opnd;
        sh_cf  = cf_in;
      end
    endcase
  end

  // R10: overflow for a single-position move
  assign res_msb  = is_word ? sh_res[DATA_W-1] : sh_res[HALF_W-1];
  assign res_nxt  = is_word ? sh_res[DATA_W-2] : sh_res[HALF_W-2];
  assign opnd_msb = is_word ? opnd[DATA_W-1] : opnd[HALF_W-1];

  always_comb begin
    unique case (op)
      OP_SHL, OP_ROL, OP_RCL: sh_of1 = res_msb ^ sh_cf;
      OP_SHR:                 sh_of1 = opnd_msb;
      OP_ROR, OP_RCR:         sh_of1 = res_msb ^ res_nxt;
      default:                sh_of1 = 1'b0;
    endcase
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CNT_IN_W = 8,
  parameter int SHAMT_W  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [3:0]          op_code,
  input  logic                is_word,
  input  logic [DATA_W-1:0]   opnd_a,
  input  logic [DATA_W-1:0]   opnd_b,
  input  logic [CNT_IN_W-1:0] imm_count,
  input  logic [CNT_IN_W-1:0] reg_count,
  input  logic                count_sel,
  input  logic                cf_in,
  input  logic                zf_in,
  input  logic                sf_in,
  input  logic                pf_in,
  input  logic                of_in,
  output logic                out_valid,
  output logic [DATA_W-1:0]   result,
  output logic                wr_en,
  output logic                cf_out,
  output logic                zf_out,
  output logic                sf_out,
  output logic                pf_out,
  output logic                of_out
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  localparam int N_ZSP = 2;

  logic [DATA_W-1:0]  width_mask, a_m, b_m;
  logic [SHAMT_W-1:0] shamt;
  logic               cnt_zero, cnt_one;
  logic [DATA_W-1:0]  bool_res, sh_res;
  logic               sh_cf, sh_of1;
  logic               is_bool, is_shift, is_rot, moves;
  flags_t             fl_in, fl_n, fl_q;
  logic [DATA_W-1:0]  res_n;
  logic               wr_n;
  logic [DATA_W-1:0]  zsp_val [N_ZSP];
  logic [N_ZSP-1:0]   zsp_z, zsp_s, zsp_p;

  // R4: byte operands use only the low half
  assign width_mask = is_word ? '1 : LOW_MASK;
  assign a_m        = opnd_a & width_mask;
  assign b_m        = opnd_b & width_mask;
  assign fl_in      = flags_t'({cf_in, zf_in, sf_in, pf_in, of_in});

  bitop_count #(.CNT_IN_W(CNT_IN_W), .SHAMT_W(SHAMT_W)) u_count (
    .imm_count(imm_count), .reg_count(reg_count), .count_sel(count_sel),
    .shamt(shamt), .cnt_zero(cnt_zero)
  );

  bitop_logic #(.DATA_W(DATA_W)) u_logic (
    .op(op_code), .a(a_m), .b(b_m), .width_mask(width_mask), .bool_res(bool_res)
  );

  bitop_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
    .op(op_code), .is_word(is_word), .opnd(a_m), .cf_in(cf_in), .shamt(shamt),
    .sh_res(sh_res), .sh_cf(sh_cf), .sh_of1(sh_of1)
  );

  // one flag generator per result source: index 0 Boolean, index 1 shifter
  assign zsp_val[0] = bool_res;
  assign zsp_val[1] = sh_res;

  for (genvar g = 0; g < N_ZSP; g++) begin : g_zsp
    bitop_zsp #(.DATA_W(DATA_W)) u_zsp (
      .value(zsp_val[g]), .is_word(is_word),
      .zf(zsp_z[g]), .sf(zsp_s[g]), .pf(zsp_p[g])
    );
  end

  assign is_bool  = op_is_bool(op_code);
  assign is_shift = op_is_shift(op_code);
  assign is_rot   = op_is_rot(op_code);
  assign moves    = (is_shift || is_rot) && !cnt_zero;
  assign cnt_one  = (shamt == SHAMT_W'(1));

  always_comb begin
    res_n = a_m;      // R9, R11: operand passes through
    wr_n  = 1'b0;
    fl_n  = fl_in;
    if (op_code == OP_NOT) begin  // R3: flags untouched
      res_n = bool_res;
      wr_n  = 1'b1;
    end else if (is_bool) begin   // R2, R3
      res_n   = bool_res;
      wr_n    = (op_code != OP_TEST);
      fl_n.cf = 1'b0;
      fl_n.of = 1'b0;
      fl_n.zf = zsp_z[0];
      fl_n.sf = zsp_s[0];
      fl_n.pf = zsp_p[0];
    end else if (moves) begin     // R6, R7, R8, R10
      res_n   = sh_res;
      wr_n    = 1'b1;
      fl_n.cf = sh_cf;
      if (cnt_one) fl_n.of = sh_of1;
      if (is_shift) begin
        fl_n.zf = zsp_z[1];
        fl_n.sf = zsp_s[1];
        fl_n.pf = zsp_p[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      result    <= '0;
      fl_q      <= '0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid & wr_n;
      if (in_valid) begin
        result <= res_n;
        fl_q   <= fl_n;
      end
    end
  end

  assign cf_out = fl_q.cf;
  assign zf_out = fl_q.zf;
  assign sf_out = fl_q.sf;
  assign pf_out = fl_q.pf;
  assign of_out = fl_q.of;

  // ---------------- assertions ----------------
  p_issue_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !wr_en));

  p_test_nowrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code == OP_TEST) |=> (!wr_en && !cf_out && !of_out));

  p_bool_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_bool) |=> (!cf_out && !of_out));

  p_byte_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_word) |=> (result[DATA_W-1:HALF_W] == '0));

  p_zero_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (is_shift || is_rot) && cnt_zero) |=>
      (!wr_en && cf_out == $past(cf_in) && zf_out == $past(zf_in) &&
       sf_out == $past(sf_in) && pf_out == $past(pf_in) && of_out == $past(of_in)));

  p_rot_keeps_zsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_rot) |=>
      (zf_out == $past(zf_in) && sf_out == $past(sf_in) && pf_out == $past(pf_in)));

  p_unused_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code >= 4'd12) |=> (!wr_en && cf_out == $past(cf_in)));

  p_multi_of_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (is_shift || is_rot) && !cnt_zero && !cnt_one) |=>
      (of_out == $past(of_in)));
endmodule

// File: tb/bitop_unit_test.sv
`timescale 1ns/1ps
module bitop_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic        is_word = 1'b0;
  logic [15:0] opnd_a = '0, opnd_b = '0;
  logic [7:0]  imm_count = '0, reg_count = '0;
  logic        count_sel = 1'b0;
  logic        cf_in = 0, zf_in = 0, sf_in = 0, pf_in = 0, of_in = 0;
  logic        out_valid, wr_en, cf_out, zf_out, sf_out, pf_out, of_out;
  logic [15:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  bitop_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .is_word(is_word), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .imm_count(imm_count), .reg_count(reg_count), .count_sel(count_sel),
    .cf_in(cf_in), .zf_in(zf_in), .sf_in(sf_in), .pf_in(pf_in), .of_in(of_in),
    .out_valid(out_valid), .result(result), .wr_en(wr_en),
    .cf_out(cf_out), .zf_out(zf_out), .sf_out(sf_out), .pf_out(pf_out), .of_out(of_out)
  );

  // expected bundle: {result[15:0], wr, cf, zf, sf, pf, of}
  function automatic logic [21:0] model(input int op, input bit word,
                                        input logic [15:0] a, input logic [15:0] b,
                                        input int cnt, input logic [4:0] fin);
    int w, top;
    logic [15:0] msk, x, r;
    logic cf, zf, sf, pf, of, wr, t, omsb;
    w   = word ? 16 : 8;
    msk = word ? 16'hFFFF : 16'h00FF;
    x   = a & msk;
    {cf, zf, sf, pf, of} = fin;
    wr  = 1'b0;
    r   = x;
    top = w - 1;
    omsb = x[top];
    if (op == 0) begin
      r = ~a & msk; wr = 1'b1;
    end else if (op >= 1 && op <= 4) begin
      case (op)
        1, 4: r = x & b & msk;
        2:    r = (x | b) & msk;
        default: r = (x ^ b) & msk;
      endcase
      wr = (op != 4); cf = 1'b0; of = 1'b0;
      zf = (r == 0); sf = r[top]; pf = ~^r[7:0];
    end else if (op >= 5 && op <= 11 && cnt != 0) begin
      for (int i = 0; i < cnt; i++) begin
        case (op)
          5:  begin cf = x[top]; x = (x << 1) & msk; end
          6:  begin cf = x[0]; x = x >> 1; end
          7:  begin cf = x[0]; x = (x >> 1) | (x & (16'h1 << top)); end
          8:  begin cf = x[top]; x = ((x << 1) | {15'b0, cf}) & msk; end
          9:  begin cf = x[0]; x = (x >> 1) | (cf ? (16'h1 << top) : 16'h0); end
          10: begin t = x[top]; x = ((x << 1) | {15'b0, cf}) & msk; cf = t; end
          default: begin t = x[0]; x = (x >> 1) | (cf ? (16'h1 << top) : 16'h0); cf = t; end
        endcase
      end
      r = x; wr = 1'b1;
      if (op <= 7) begin zf = (r == 0); sf = r[top]; pf = ~^r[7:0]; end
      if (cnt == 1) begin
        case (op)
          5, 8, 10: of = r[top] ^ cf;
          6:        of = omsb;
          7:        of = 1'b0;
          default:  of = r[top] ^ r[top-1];
        endcase
      end
    end
    return {r, wr, cf, zf, sf, pf, of};
  endfunction

  function automatic string tag_for(input int op, input bit word, input int cnt);
    if (op >= 12) return "R11";
    if (op >= 5 && cnt == 0) return "R9";
    if (op >= 5 && cnt == 1) return "R10";
    if (!word && op <= 4) return "R4";
    if (op == 4) return "R2";
    if (op <= 3) return "R3";
    if (op <= 7) return "R6";
    if (op <= 9) return "R7";
    return "R8";
  endfunction

  task automatic check_bundle(input string tag, input logic [21:0] exp);
    logic [21:0] act;
    act = {result, wr_en, cf_out, zf_out, sf_out, pf_out, of_out};
    n_checks++;
    if (act !== exp || out_valid !== 1'b1) begin
      n_fail++;
      $display("FAIL %s: actual res=%h wr/cf/zf/sf/pf/of=%b valid=%b expected res=%h wr/cf/zf/sf/pf/of=%b",
               tag, act[21:6], act[5:0], out_valid, exp[21:6], exp[5:0]);
    end
  endtask

  task automatic run_op(input int op, input bit word, input logic [15:0] a,
                        input logic [15:0] b, input logic [7:0] imm,
                        input logic [7:0] rc, input bit sel,
                        input logic [4:0] fin, input string tag_force);
    int c;
    logic [21:0] exp;
    string tag;
    c   = int'((sel ? rc : imm) & 8'h1F);
    exp = model(op, word, a, b, c, fin);
    tag = (tag_force.len() != 0) ? tag_force : tag_for(op, word, c);
    @(negedge clk);
    in_valid = 1'b1; op_code = 4'(op); is_word = word; opnd_a = a; opnd_b = b;
    imm_count = imm; reg_count = rc; count_sel = sel;
    {cf_in, zf_in, sf_in, pf_in, of_in} = fin;
    @(negedge clk);
    in_valid = 1'b0;
    check_bundle(tag, exp);
  endtask

  initial begin
    logic [15:0] pa [4];
    logic [15:0] pb [4];
    pa = '{16'h8001, 16'h00C5, 16'h7F80, 16'h0000};
    pb = '{16'hFF0F, 16'h0F3A, 16'h8080, 16'hFFFF};

    // R12: reset state
    repeat (3) @(negedge clk);
    n_checks++;
    if ({out_valid, wr_en, result, cf_out, zf_out, sf_out, pf_out, of_out} !== '0) begin
      n_fail++;
      $display("FAIL R12: actual valid=%b wr=%b res=%h flags=%b expected all zero",
               out_valid, wr_en, result, {cf_out, zf_out, sf_out, pf_out, of_out});
    end
    rst_n = 1'b1;

    // exhaustive sweep: every code, both widths, every count, four patterns
    for (int op = 0; op < 16; op++)
      for (int wd = 0; wd < 2; wd++)
        for (int c = 0; c < 32; c++)
          for (int p = 0; p < 4; p++) begin
            logic [7:0] sel_val, other;
            bit sel;
            sel     = c[0] ^ p[0];
            sel_val = 8'(c) | (p[1] ? 8'hE0 : 8'h20);  // R5: junk above bit 4
            other   = 8'(31 - c);
            run_op(op, wd[0], pa[p], pb[p],
                   sel ? other : sel_val, sel ? sel_val : other, sel,
                   5'(op * 7 + c + p * 3), "");
          end

    // R5: directed count-source checks
    run_op(5, 1'b1, 16'h4001, 16'h0, 8'h21, 8'h03, 1'b0, 5'b00000, "R5");
    run_op(5, 1'b1, 16'h4001, 16'h0, 8'h21, 8'h03, 1'b1, 5'b00000, "R5");
    run_op(6, 1'b0, 16'h00F0, 16'h0, 8'h02, 8'h40, 1'b1, 5'b11111, "R5");

    // R1: idle cycle after an operation drops valid and write
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || wr_en !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: actual valid=%b wr=%b expected valid=0 wr=0", out_valid, wr_en);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule